// File: doc/BRIEF.md
# Boosted Overlap Local-Inhibition Selector

This block scores every column of a spatial pooler against one binary input vector and then thins the result into a sparse activation pattern. A column's raw overlap is the number of its connected synapses whose input line is active. That count is scaled by the column's own boost value to give the boosted score. The columns are split into fixed inhibition zones. Each zone keeps only the columns whose boosted score lies close to the best score seen in that zone for the current vector, and never more than a fixed number of them.

A single-cycle start pulse launches one evaluation. All zones work in parallel. Each zone walks its columns one per cycle and keeps a small ranked list of the best candidates. One extra cycle then compares that list against the zone maximum and the programmable margin. A done pulse marks the cycle in which the per-column activation bits become valid. Those bits hold until the next accepted start. Synapse learning and boost adaptation sit outside this block.

Top module: `sp_inhibit_select`

## Requirements
- R1: The boosted score of column c is popcount(`in_vec` AND synapse row c) multiplied by boost c. Synapse row c is `syn_map[c*N_IN +: N_IN]` and boost c is `boost[c*BOOST_W +: BOOST_W]`. The multiplication is full precision, and a higher score ranks ahead of a lower one.
- R2: Zone z holds columns z*ZONE_COLS to z*ZONE_COLS+ZONE_COLS-1. The winners of a zone depend only on the scores of that zone's own columns.
- R3: No zone ever has more than MAX_WIN bits of `winners` set.
- R4: A column is a candidate when its score is nonzero and score + `margin` >= the largest score in its zone for the current vector.
- R5: When a zone has more candidates than MAX_WIN, the higher scores are kept first. Among equal scores, the lower column index is kept.
- R6: A zone whose maximum score is zero, for example because all inputs are inactive, sets no winner bit.
- R7: `done` is high for exactly one cycle. It appears ZONE_COLS+1 cycles after the clock edge that accepts `start`, and `winners` is valid in that cycle. `in_vec`, `syn_map`, `boost` and `margin` must stay stable from the accepting edge until `done`.
- R8: `winners` is cleared on the edge that accepts `start`. It then changes only on the edge that raises `done`, and it holds its value until the next accepted start.
- R9: A `start` pulse that arrives while an evaluation is in progress is ignored. The running evaluation keeps its timing and its result.
- R10: Synchronous reset clears `done` and `winners`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin evaluation of the current vector |
| margin | input | clog2(N_IN+1)+BOOST_W | Allowed distance below the zone maximum |
| in_vec | input | N_IN | Binary input vector |
| syn_map | input | NUM_ZONES*ZONE_COLS*N_IN | Connected-synapse bitmap, one N_IN row per column |
| boost | input | NUM_ZONES*ZONE_COLS*BOOST_W | Boost value per column |
| done | output | 1 | One-cycle pulse: results valid |
| winners | output | NUM_ZONES*ZONE_COLS | Activation bit per column |

## Verification
Results are due exactly ZONE_COLS+1 cycles after the edge that accepts start. The clear of the activation bits is due on that accepting edge. The bench drives inputs on falling edges and counts falling edges from the accepting edge to the first one that shows done. It requires that count to equal ZONE_COLS+1, and only then compares the activation bits with a reference selection computed from the requirements. It checks the cleared bits one half cycle after acceptance, and it samples twice more after done to confirm that the bits hold and that done has dropped.

// File: rtl/sp_sel_pkg.sv
package sp_sel_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SCAN   = 2'd1,
        PH_DECIDE = 2'd2
    } phase_e;

    // index width that stays legal for a one-entry range
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // bits needed for an overlap count of up to n synapses
    function automatic int count_width(input int n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/sp_col_score.sv
module sp_col_score #(
    parameter int N_IN    = 6,
    parameter int BOOST_W = 3,
    parameter int CNT_W   = sp_sel_pkg::count_width(N_IN),
    parameter int SCORE_W = CNT_W + BOOST_W
) (
    input  logic [N_IN-1:0]    in_vec,
    input  logic [N_IN-1:0]    syn_row,
    input  logic [BOOST_W-1:0] boost_val,
    output logic [SCORE_W-1:0] score
);
    logic [CNT_W-1:0] overlap;

    always_comb begin
        overlap = CNT_W'($countones(in_vec & syn_row));
        score   = {{BOOST_W{1'b0}}, overlap} * {{CNT_W{1'b0}}, boost_val};
    end
endmodule

// File: rtl/sp_zone_rank.sv
module sp_zone_rank #(
    parameter int SCORE_W = 6,
    parameter int IDX_W   = 3,
    parameter int MAX_WIN = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clear,
    input  logic                       shift_en,
    input  logic [SCORE_W-1:0]         in_score,
    input  logic [IDX_W-1:0]           in_idx,
    output logic [MAX_WIN*SCORE_W-1:0] slot_score,
    output logic [MAX_WIN*IDX_W-1:0]   slot_idx
);
    logic [SCORE_W-1:0] s_q [MAX_WIN];
    logic [IDX_W-1:0]   i_q [MAX_WIN];
    logic [MAX_WIN-1:0] beats;

    for (genvar k = 0; k < MAX_WIN; k++) begin : g_slot
        // strict compare: an equal later column never displaces an earlier one
        assign beats[k] = in_score > s_q[k];
        assign slot_score[k*SCORE_W +: SCORE_W] = s_q[k];
        assign slot_idx[k*IDX_W +: IDX_W]       = i_q[k];

        if (k == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst || clear) begin
                    s_q[k] <= '0;
                    i_q[k] <= '0;
                end else if (shift_en && beats[k]) begin
                    s_q[k] <= in_score;
                    i_q[k] <= in_idx;
                end
            end
        end else begin : g_tail
            always_ff @(posedge clk) begin
                if (rst || clear) begin
                    s_q[k] <= '0;
                    i_q[k] <= '0;
                end else if (shift_en) begin
                    if (beats[k-1]) begin
                        s_q[k] <= s_q[k-1];
                        i_q[k] <= i_q[k-1];
                    end else if (beats[k]) begin
                        s_q[k] <= in_score;
                        i_q[k] <= in_idx;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/sp_zone_decide.sv
module sp_zone_decide #(
    parameter int ZONE_COLS = 8,
    parameter int SCORE_W   = 6,
    parameter int IDX_W     = 3,
    parameter int MAX_WIN   = 2
) (
    input  logic [MAX_WIN*SCORE_W-1:0] slot_score,
    input  logic [MAX_WIN*IDX_W-1:0]   slot_idx,
    input  logic [SCORE_W-1:0]         margin,
    output logic [ZONE_COLS-1:0]       win_mask
);
    logic [SCORE_W-1:0] top;
    logic [SCORE_W:0]   reach;
    logic [SCORE_W-1:0] s_k;
    logic [IDX_W-1:0]   i_k;

    always_comb begin
        top      = slot_score[SCORE_W-1:0];
        win_mask = '0;
        reach    = '0;
        s_k      = '0;
        i_k      = '0;
        for (int k = 0; k < MAX_WIN; k++) begin
            s_k   = slot_score[k*SCORE_W +: SCORE_W];
            i_k   = slot_idx[k*IDX_W +: IDX_W];
            reach = {1'b0, s_k} + {1'b0, margin};
            if ((s_k != '0) && (reach >= {1'b0, top}))
                win_mask[i_k] = 1'b1;
        end
    end
endmodule

// File: rtl/sp_inhibit_select.sv
module sp_inhibit_select #(
    parameter int NUM_ZONES = 2,
    parameter int ZONE_COLS = 64,
    parameter int N_IN      = 16,
    parameter int BOOST_W   = 4,
    parameter int MAX_WIN   = 2
) (
    input  logic                                       clk,
    input  logic                                       rst,
    input  logic                                       start,
    input  logic [$clog2(N_IN+1)+BOOST_W-1:0]          margin,
    input  logic [N_IN-1:0]                            in_vec,
    input  logic [NUM_ZONES*ZONE_COLS*N_IN-1:0]        syn_map,
    input  logic [NUM_ZONES*ZONE_COLS*BOOST_W-1:0]     boost,
    output logic                                       done,
    output logic [NUM_ZONES*ZONE_COLS-1:0]             winners
);
    import sp_sel_pkg::*;

    localparam int NUM_COLS = NUM_ZONES * ZONE_COLS;
    localparam int CNT_W    = count_width(N_IN);
    localparam int SCORE_W  = CNT_W + BOOST_W;
    localparam int IDX_W    = idx_width(ZONE_COLS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ZONE_COLS - 1);

    phase_e            phase_q;
    logic [IDX_W-1:0]  scan_idx;
    logic              accept;
    logic              shift_en;
    logic [NUM_COLS-1:0] mask_all;

    assign accept   = (phase_q == PH_IDLE) && start;
    assign shift_en = (phase_q == PH_SCAN);

    for (genvar z = 0; z < NUM_ZONES; z++) begin : g_zone
        logic [N_IN-1:0]            row_sel;
        logic [BOOST_W-1:0]         boost_sel;
        logic [SCORE_W-1:0]         score;
        logic [MAX_WIN*SCORE_W-1:0] slot_score;
        logic [MAX_WIN*IDX_W-1:0]   slot_idx;

        always_comb begin
            row_sel   = syn_map[(z*ZONE_COLS + int'(scan_idx))*N_IN +: N_IN];
            boost_sel = boost[(z*ZONE_COLS + int'(scan_idx))*BOOST_W +: BOOST_W];
        end

        sp_col_score #(
            .N_IN(N_IN), .BOOST_W(BOOST_W), .CNT_W(CNT_W), .SCORE_W(SCORE_W)
        ) u_score (
            .in_vec(in_vec), .syn_row(row_sel), .boost_val(boost_sel), .score(score)
        );

        sp_zone_rank #(
            .SCORE_W(SCORE_W), .IDX_W(IDX_W), .MAX_WIN(MAX_WIN)
        ) u_rank (
            .clk(clk), .rst(rst), .clear(accept), .shift_en(shift_en),
            .in_score(score), .in_idx(scan_idx),
            .slot_score(slot_score), .slot_idx(slot_idx)
        );

        sp_zone_decide #(
            .ZONE_COLS(ZONE_COLS), .SCORE_W(SCORE_W), .IDX_W(IDX_W), .MAX_WIN(MAX_WIN)
        ) u_decide (
            .slot_score(slot_score), .slot_idx(slot_idx), .margin(margin),
            .win_mask(mask_all[z*ZONE_COLS +: ZONE_COLS])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_IDLE;
            scan_idx <= '0;
            done     <= 1'b0;
            winners  <= '0;
        end else begin
            done <= 1'b0;
            unique case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        phase_q  <= PH_SCAN;
                        scan_idx <= '0;
                        winners  <= '0;
                    end
                end
                PH_SCAN: begin
                    if (scan_idx == LAST_IDX) begin
                        phase_q <= PH_DECIDE;
                    end else begin
                        scan_idx <= scan_idx + 1'b1;
                    end
                end
                PH_DECIDE: begin
                    winners <= mask_all;
                    done    <= 1'b1;
                    phase_q <= PH_IDLE;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sp_inhibit_select_chk.sv
module sp_inhibit_select_chk #(
    parameter int NUM_ZONES = 2,
    parameter int ZONE_COLS = 64,
    parameter int MAX_WIN   = 2
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           start,
    input logic                           done,
    input logic [NUM_ZONES*ZONE_COLS-1:0] winners
);
    logic busy_c;
    int   cnt_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_c <= 1'b0;
            cnt_c  <= 0;
        end else if (!busy_c) begin
            if (start) begin
                busy_c <= 1'b1;
                cnt_c  <= 0;
            end
        end else begin
            cnt_c <= cnt_c + 1;
            if (cnt_c == ZONE_COLS) busy_c <= 1'b0;
        end
    end

    // R7: done only at the fixed latency after an accepted start
    p_done_latency_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy_c && cnt_c == ZONE_COLS + 1));

    // R7: done arrives when due
    p_done_due_r7: assert property (@(posedge clk) disable iff (rst)
        (busy_c && cnt_c == ZONE_COLS) |=> done);

    // R7: single-cycle pulse
    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: outputs move only at acceptance or at completion
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !$stable(winners) |-> (done || $past(start)));

    // R8: accepted start clears the activation bits
    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (start && !busy_c) |=> (winners == '0));

    for (genvar z = 0; z < NUM_ZONES; z++) begin : g_cap
        // R3: per-zone cap
        p_cap_r3: assert property (@(posedge clk) disable iff (rst)
            $countones(winners[z*ZONE_COLS +: ZONE_COLS]) <= MAX_WIN);
    end
endmodule

bind sp_inhibit_select sp_inhibit_select_chk #(
    .NUM_ZONES(NUM_ZONES), .ZONE_COLS(ZONE_COLS), .MAX_WIN(MAX_WIN)
) u_chk (
    .clk(clk), .rst(rst), .start(start), .done(done), .winners(winners)
);

// File: tb/tb_sp_inhibit_select.sv
module tb_sp_inhibit_select;
    localparam int CLK_PERIOD = 10;
    localparam int NZ = 2;
    localparam int ZC = 8;
    localparam int NI = 6;
    localparam int BW = 3;
    localparam int MW = 2;
    localparam int NC = NZ * ZC;
    localparam int SW = $clog2(NI + 1) + BW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [SW-1:0] margin = '0;
    logic [NI-1:0] in_vec = '0;
    logic [NC*NI-1:0] syn_map;
    logic [NC*BW-1:0] boost;
    logic done;
    logic [NC-1:0] winners;

    logic [NI-1:0] syn_a [NC];
    logic [BW-1:0] boost_a [NC];

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int c = 0; c < NC; c++) begin
            syn_map[c*NI +: NI]  = syn_a[c];
            boost[c*BW +: BW]    = boost_a[c];
        end
    end

    sp_inhibit_select #(
        .NUM_ZONES(NZ), .ZONE_COLS(ZC), .N_IN(NI), .BOOST_W(BW), .MAX_WIN(MW)
    ) dut (
        .clk(clk), .rst(rst), .start(start), .margin(margin), .in_vec(in_vec),
        .syn_map(syn_map), .boost(boost), .done(done), .winners(winners)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // reference selection written from the requirements
    function automatic logic [NC-1:0] model();
        logic [NC-1:0] m = '0;
        int sc [NC];
        for (int c = 0; c < NC; c++)
            sc[c] = $countones(in_vec & syn_a[c]) * int'(boost_a[c]);
        for (int z = 0; z < NZ; z++) begin
            int mx = 0;
            for (int c = z*ZC; c < z*ZC + ZC; c++) if (sc[c] > mx) mx = sc[c];
            for (int n = 0; n < MW; n++) begin
                int best = -1;
                for (int c = z*ZC; c < z*ZC + ZC; c++) begin
                    if (!m[c] && sc[c] > 0 && sc[c] + int'(margin) >= mx &&
                        (best < 0 || sc[c] > sc[best])) best = c;
                end
                if (best >= 0) m[best] = 1'b1;
            end
        end
        return m;
    endfunction

    task automatic run_vec(input string req, input bit poke_busy);
        logic [NC-1:0] exp_w;
        int cnt = 0;
        bit got = 0;
        exp_w = model();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R8 clear", 64'(winners), 64'(0));
        while (!got && cnt < 40) begin
            @(negedge clk);
            cnt++;
            start = (poke_busy && cnt == 3);
            if (done) got = 1;
        end
        start = 1'b0;
        check(poke_busy ? "R9 latency" : "R7 latency", 64'(cnt), 64'(ZC + 1));
        check(req, 64'(winners), 64'(exp_w));
        for (int z = 0; z < NZ; z++)
            check("R3 cap", 64'($countones(winners[z*ZC +: ZC]) <= MW), 64'(1));
        @(negedge clk);
        @(negedge clk);
        check("R7 pulse", 64'(done), 64'(0));
        check("R8 hold", 64'(winners), 64'(exp_w));
    endtask

    task automatic clear_cfg();
        for (int c = 0; c < NC; c++) begin
            syn_a[c]   = '0;
            boost_a[c] = '0;
        end
    endtask

    initial begin
        repeat (1000000 / CLK_PERIOD) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        clear_cfg();
        repeat (3) @(negedge clk);
        check("R10 done", 64'(done), 64'(0));
        check("R10 winners", 64'(winners), 64'(0));
        rst = 1'b0;

        // R6: all inputs inactive
        for (int c = 0; c < NC; c++) begin syn_a[c] = '1; boost_a[c] = 3'd7; end
        in_vec = '0; margin = 6'd5;
        run_vec("R6 zero max", 0);

        // R1: boost scaling decides the winner
        clear_cfg(); in_vec = 6'b111111; margin = '0;
        syn_a[2] = 6'b001111; boost_a[2] = 3'd1;   // 4
        syn_a[5] = 6'b000001; boost_a[5] = 3'd5;   // 5
        run_vec("R1 product", 0);

        // R5: three-way tie, lowest indices kept
        clear_cfg(); in_vec = 6'b111111; margin = '0;
        syn_a[1] = 6'b000111; boost_a[1] = 3'd2;   // 6
        syn_a[3] = 6'b000011; boost_a[3] = 3'd3;   // 6
        syn_a[6] = 6'b111111; boost_a[6] = 3'd1;   // 6
        run_vec("R5 tie", 0);

        // R5: highest scores kept over lower index
        clear_cfg(); in_vec = 6'b111111; margin = 6'd10;
        syn_a[0] = 6'b000001; boost_a[0] = 3'd2;   // 2
        syn_a[4] = 6'b000111; boost_a[4] = 3'd2;   // 6
        syn_a[7] = 6'b001111; boost_a[7] = 3'd2;   // 8
        run_vec("R5 rank", 0);

        // R4: margin boundary, 8 vs 6 with margin 2 then 1
        margin = 6'd2; syn_a[4] = 6'b000111; syn_a[0] = '0;
        run_vec("R4 edge in", 0);
        margin = 6'd1;
        run_vec("R4 edge out", 0);

        // R2: zone 0 silent, zone 1 active
        clear_cfg(); in_vec = 6'b101010; margin = '0;
        syn_a[ZC + 2] = 6'b101000; boost_a[ZC + 2] = 3'd3;
        syn_a[3]      = 6'b010101; boost_a[3]      = 3'd7;
        run_vec("R2 zones", 0);

        // R9: start while busy
        run_vec("R9 busy", 1);

        // sweep over random configurations
        for (int t = 0; t < 400; t++) begin
            bit flat = (t % 4 == 0);
            for (int c = 0; c < NC; c++) begin
                syn_a[c]   = NI'($urandom());
                boost_a[c] = flat ? 3'd2 : BW'($urandom());
            end
            in_vec = NI'($urandom());
            margin = (t % 3 == 0) ? '0 : SW'($urandom() % 9);
            run_vec("R1 R4 R5 sweep", (t % 7 == 0));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule